// File: doc/BRIEF.md
# Latched Serial Switch-Control Register

This block holds the control bits for a bank of on/off channels, 32 by default. A host loads them one bit at a time. Each bit goes into a shift register on any clock cycle in which the serial strobe is high. The register's last stage is driven out on a chain output, so several of these blocks can be connected output to input and loaded with a single long stream. The channel bit for the highest channel goes in first. Once a full frame has been shifted, stage k holds the control for channel k.

A bank of latches sits between the shift register and the channel-enable outputs. The latch enable is active low. While it is low the latches are transparent, and the outputs follow the shift register. When it goes high the latches hold their value, and any further shifting cannot disturb the channels. A clear input switches every channel off at once without waiting for a clock. It takes priority over the latch enable and leaves the shift register untouched. A synchronous reset zeroes both the shift register and the latches.

Top module: `sersw_top`

## Requirements
- R1: On each rising clock edge with `bitValid` high, `serIn` is stored in stage 0 and every stage k moves to stage k+1.
- R2: After 32 strobed bits and a latch-enable low pulse, the first bit sent appears on `chanOn[31]` and the last bit sent appears on `chanOn[0]`.
- R3: `chainOut` always equals the content of the top shift stage (stage 31), so it shows the oldest bit still held.
- R4: While `latchEnN` is 0 and `clrLatch` is 0, `chanOn` equals the shift-register contents and follows every shift within the same cycle.
- R5: While `latchEnN` is 1, `chanOn` keeps the value it had when `latchEnN` rose, no matter how many bits are shifted.
- R6: While `clrLatch` is 1, `chanOn` is all zero immediately and without a clock, even when `latchEnN` is 0. After `clrLatch` falls with `latchEnN` at 1, `chanOn` stays all zero.
- R7: `clrLatch` does not alter the shift register, and shifting continues while it is high. Shifted data is still present after it falls and can be latched later.
- R8: A synchronous `rst` sets the shift register and the latches to zero, so `chanOn` is 0 and `chainOut` is 0.
- R9: On a clock edge with `bitValid` low, the shift register keeps its contents.
- R10: Each `chanOn` bit is independent. A 1 switches that channel on and a 0 switches it off, for any pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| bitValid | input | 1 | Shifts `serIn` in at this clock edge |
| serIn | input | 1 | Serial control data |
| latchEnN | input | 1 | Latch enable, active low (low = transparent) |
| clrLatch | input | 1 | Asynchronous clear of the latch bank, active high |
| chainOut | output | 1 | Top shift stage, for the next block in the chain |
| chanOn | output | 32 | Per-channel enable, 1 = on |

## Verification
The hardest case to reach is the interplay of clear with the other controls. This covers a clear raised while the latches are transparent, bits shifted during the clear, and the clear released while the enable is already high. After that sequence the outputs must stay off, the chain output must still show the shifted stream, and a later enable pulse must reveal it. The bench drives this exact order of edges as a directed case. It also streams bits while the latch is transparent, to show the outputs following every shift. Random frames from a seeded generator cover pattern independence and the hold behaviour.

// File: rtl/sersw_pkg.sv
package sersw_pkg;
  typedef struct packed {
    logic doShift;
    logic doReset;
  } shiftStb_t;

  typedef struct packed {
    logic doCapture;
    logic doBlank;
    logic doReset;
  } latchStb_t;
endpackage

// File: rtl/sersw_ctrl.sv
module sersw_ctrl
  import sersw_pkg::*;
(
  input  logic      rst,
  input  logic      bitValid,
  input  logic      latchEnN,
  input  logic      clrLatch,
  output shiftStb_t shStb,
  output latchStb_t ltStb
);
  always_comb begin
    shStb.doReset = rst;
    shStb.doShift = bitValid & ~rst;
    ltStb.doReset   = rst;
    ltStb.doBlank   = clrLatch;
    ltStb.doCapture = ~latchEnN & ~clrLatch;
  end
endmodule

// File: rtl/sersw_shift.sv
module sersw_shift
  import sersw_pkg::*;
#(
  parameter int NumChan = 32
) (
  input  logic               clk,
  input  shiftStb_t          shStb,
  input  logic               serIn,
  output logic [NumChan-1:0] shiftQ,
  output logic [NumChan-1:0] shiftD,
  output logic               chainOut
);
  localparam int TopIdx = NumChan - 1;

  always_comb begin
    if (shStb.doReset)      shiftD = '0;
    else if (shStb.doShift) shiftD = {shiftQ[TopIdx-1:0], serIn};
    else                    shiftD = shiftQ;
  end

  always_ff @(posedge clk) shiftQ <= shiftD;

  assign chainOut = shiftQ[TopIdx];

  assert_shift_entry_R1: assert property (@(posedge clk) disable iff (shStb.doReset)
    shStb.doShift |=> shiftQ[0] == $past(serIn));
  assert_chain_oldest_R3: assert property (@(posedge clk) disable iff (shStb.doReset)
    shStb.doShift |=> chainOut == $past(shiftQ[TopIdx-1]));
  assert_idle_keeps_R9: assert property (@(posedge clk) disable iff (shStb.doReset)
    !shStb.doShift |=> $stable(shiftQ));
endmodule

// File: rtl/sersw_latch.sv
module sersw_latch
  import sersw_pkg::*;
#(
  parameter int NumChan = 32
) (
  input  logic               clk,
  input  latchStb_t          ltStb,
  input  logic [NumChan-1:0] shiftQ,
  input  logic [NumChan-1:0] shiftD,
  output logic [NumChan-1:0] chanOn
);
  logic [NumChan-1:0] heldQ;

  always_ff @(posedge clk or posedge ltStb.doBlank) begin
    if (ltStb.doBlank)        heldQ <= '0;
    else if (ltStb.doReset)   heldQ <= '0;
    else if (ltStb.doCapture) heldQ <= shiftD;
  end

  assign chanOn = ltStb.doBlank ? '0 : (ltStb.doCapture ? shiftQ : heldQ);

  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (ltStb.doReset)
    (!ltStb.doCapture && !$past(ltStb.doCapture) && !ltStb.doBlank && !$past(ltStb.doBlank)
     && !$past(ltStb.doReset)) |-> $stable(chanOn));
endmodule

// File: rtl/sersw_top.sv
module sersw_top
  import sersw_pkg::*;
#(
  parameter int NumChan = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bitValid,
  input  logic               serIn,
  input  logic               latchEnN,
  input  logic               clrLatch,
  output logic               chainOut,
  output logic [NumChan-1:0] chanOn
);
  shiftStb_t          shStb;
  latchStb_t          ltStb;
  logic [NumChan-1:0] shiftQ;
  logic [NumChan-1:0] shiftD;

  sersw_ctrl u_ctrl (
    .rst(rst), .bitValid(bitValid), .latchEnN(latchEnN), .clrLatch(clrLatch),
    .shStb(shStb), .ltStb(ltStb)
  );

  sersw_shift #(.NumChan(NumChan)) u_shift (
    .clk(clk), .shStb(shStb), .serIn(serIn),
    .shiftQ(shiftQ), .shiftD(shiftD), .chainOut(chainOut)
  );

  sersw_latch #(.NumChan(NumChan)) u_latch (
    .clk(clk), .ltStb(ltStb), .shiftQ(shiftQ), .shiftD(shiftD), .chanOn(chanOn)
  );

  assert_transparent_R4: assert property (@(posedge clk) disable iff (rst)
    (!latchEnN && !clrLatch) |-> chanOn == shiftQ);
  assert_clear_off_R6: assert property (@(posedge clk) disable iff (rst)
    clrLatch |-> chanOn == '0);
  assert_clear_spares_shift_R7: assert property (@(posedge clk) disable iff (rst)
    (clrLatch && !bitValid) |=> $stable(shiftQ));
endmodule

// File: tb/sersw_top_test.sv
module sersw_top_test;
  localparam int N = 32;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bitValid = 1'b0;
  logic serIn = 1'b0;
  logic latchEnN = 1'b1;
  logic clrLatch = 1'b0;
  logic chainOut;
  logic [N-1:0] chanOn;

  int nRun = 0;
  int nFail = 0;
  logic [N-1:0] mdl = '0;
  logic [N-1:0] latched = '0;

  always #2.5 clk = ~clk;

  sersw_top #(.NumChan(N)) uut (
    .clk(clk), .rst(rst), .bitValid(bitValid), .serIn(serIn),
    .latchEnN(latchEnN), .clrLatch(clrLatch), .chainOut(chainOut), .chanOn(chanOn)
  );

  function automatic logic [N-1:0] shiftModel(logic [N-1:0] s, logic b);
    return {s[N-2:0], b};
  endfunction

  task automatic chk(string req, logic [N-1:0] act, logic [N-1:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic shiftBit(logic b);
    @(negedge clk);
    serIn = b; bitValid = 1'b1;
    @(posedge clk); #1;
    mdl = shiftModel(mdl, b);
    bitValid = 1'b0;
  endtask

  task automatic loadWord(logic [N-1:0] w, bit holdChk);
    for (int i = N - 1; i >= 0; i--) begin
      shiftBit(w[i]);
      chk("R3 chain", {{(N-1){1'b0}}, chainOut}, {{(N-1){1'b0}}, mdl[N-1]});
      if (holdChk) chk("R5 hold", chanOn, latched);
    end
  endtask

  task automatic pulseLe();
    @(negedge clk); latchEnN = 1'b0; #1;
    chk("R4 transparent", chanOn, mdl);
    @(negedge clk); latchEnN = 1'b1; #1;
    latched = mdl;
    chk("R5 captured", chanOn, latched);
  endtask

  initial begin
    logic [N-1:0] w;
    logic saveChain;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0; #1;
    chk("R8 reset chanOn", chanOn, '0);
    chk("R8 reset chain", {{(N-1){1'b0}}, chainOut}, '0);

    // R2 order and R5 hold while loading
    w = 32'hA5C3_0F81;
    loadWord(w, 1'b1);
    chk("R1 shift frame", mdl, w);
    pulseLe();
    chk("R2 first bit on ch31", {{(N-1){1'b0}}, chanOn[N-1]}, {{(N-1){1'b0}}, w[N-1]});
    chk("R2 last bit on ch0", {{(N-1){1'b0}}, chanOn[0]}, {{(N-1){1'b0}}, w[0]});
    chk("R10 pattern", chanOn, w);

    // R9 idle cycles: no shift
    saveChain = chainOut;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); serIn = ~serIn; bitValid = 1'b0;
      @(posedge clk); #1;
      chk("R9 idle chain", {{(N-1){1'b0}}, chainOut}, {{(N-1){1'b0}}, saveChain});
    end
    pulseLe();
    chk("R9 idle content", chanOn, w);

    // random frames, R10 independence
    for (int k = 0; k < 20; k++) begin
      w = $urandom;
      loadWord(w, 1'b1);
      pulseLe();
      chk("R10 random pattern", chanOn, w);
    end
    loadWord(32'h0000_0000, 1'b1); pulseLe(); chk("R10 all off", chanOn, '0);
    loadWord(32'hFFFF_FFFF, 1'b1); pulseLe(); chk("R10 all on", chanOn, '1);

    // R6 / R7 clear sequence
    w = 32'h1234_8765;
    loadWord(w, 1'b1);
    pulseLe();
    @(negedge clk); clrLatch = 1'b1; #1;
    chk("R6 clear immediate", chanOn, '0);
    @(negedge clk); latchEnN = 1'b0; #1;
    chk("R6 clear beats enable", chanOn, '0);
    for (int i = 0; i < 5; i++) begin
      shiftBit(i[0]);
      chk("R6 clear during shift", chanOn, '0);
      chk("R7 chain during clear", {{(N-1){1'b0}}, chainOut}, {{(N-1){1'b0}}, mdl[N-1]});
    end
    @(negedge clk); latchEnN = 1'b1; clrLatch = 1'b0; #1;
    latched = '0;
    chk("R6 stays off after release", chanOn, '0);
    chk("R7 chain kept", {{(N-1){1'b0}}, chainOut}, {{(N-1){1'b0}}, mdl[N-1]});
    pulseLe();
    chk("R7 kept data latched", chanOn, shiftModel(shiftModel(shiftModel(shiftModel(shiftModel(w, 1'b0), 1'b1), 1'b0), 1'b1), 1'b0));

    // R4 streaming while transparent
    @(negedge clk); latchEnN = 1'b0;
    for (int i = 0; i < 8; i++) begin
      shiftBit(1'($urandom));
      chk("R4 follows shift", chanOn, mdl);
    end
    @(negedge clk); latchEnN = 1'b1; #1;
    latched = mdl;
    chk("R5 after stream", chanOn, latched);

    // R8 reset with data present
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0; #1;
    mdl = '0;
    chk("R8 reset clears latch", chanOn, '0);
    chk("R8 reset clears shift", {{(N-1){1'b0}}, chainOut}, '0);
    pulseLe();
    chk("R8 shift zero", chanOn, '0);

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    nRun++; nFail++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule